// File: doc/BRIEF.md
# Algebraic Hash Permutation Core

This block computes a width-12 algebraic hash permutation over the prime field with modulus p = 2^64 − 2^32 + 1. A caller offers a 12-element state together with a tag on a valid/ready handshake. After exactly 22 clock cycles the permuted state comes out with the same tag as a one-cycle `out_valid` pulse. Before the first round the input passes once through the external linear layer. Each of the 22 rounds then runs in one cycle: constant addition, a degree-7 power S-box, and a linear mix.

The core holds four execution slots. Each slot is a small state machine that walks one permutation through its rounds. The slot states are `SL_IDLE` (empty), `SL_HEAD` (leading full rounds), `SL_PART` (partial rounds) and `SL_TAIL` (trailing full rounds). The transitions are:
- `SL_IDLE` → `SL_HEAD` when the slot is loaded.
- `SL_HEAD` → `SL_PART` after the last leading full round.
- `SL_PART` → `SL_TAIL` after the last partial round.
- `SL_TAIL` → `SL_IDLE` after round 21, or `SL_TAIL` → `SL_HEAD` when a new state is loaded in that same cycle.

Every permutation has the same latency and at most one state is accepted per cycle. Results therefore leave in acceptance order. Inputs must be canonical field elements (each below p). `LANES` must be a multiple of 4 and at most 15.

Top module: `alg_perm_core`

## Requirements
- R1: All arithmetic is modulo p = 2^64 − 2^32 + 1. Every output lane is canonical (below p), including for inputs with all lanes equal to p − 1.
- R2: The round schedule is as follows. First, the external layer is applied once to the input. Rounds 0–3 and 18–21 are full rounds; rounds 4–17 are partial rounds. In each round, constants are added, then x ↦ x^7 is applied, then the state is mixed. Full rounds add constants and apply the S-box on all lanes. Partial rounds do both on lane 0 only.
- R3: The external layer splits the state into blocks of 4 lanes (lanes 4b..4b+3). Each block is multiplied by the 4×4 matrix with rows [5 7 1 3], [4 6 1 1], [1 3 5 7], [1 1 4 6], giving t. Output lane i is t_i plus the sum of t over all lanes with the same index mod 4. This layer is used for the pre-layer and for full rounds.
- R4: The internal layer, used in partial rounds, sets output lane i to S + (i+1)·x_i, where S is the sum of all input lanes.
- R5: The round constant for round r and lane l is defined as follows. Let v = ((r·12 + l + 1) · 0x9E3779B97F4A7C15) mod 2^64. Then v ← v XOR (v >> 29), and the constant is v mod p.
- R6: `out_valid` rises exactly 22 rising edges after the edge that accepts the input.
- R7: Up to 4 permutations are in flight. `in_ready` is low while all four slots are busy and none is in round 21. A slot in round 21 may accept a new state, so a held input stream is accepted on cycles 0, 1, 2, 3, 22, 23, and so on.
- R8: Results leave in acceptance order, and each carries the tag it was accepted with.
- R9: During and right after reset, `in_ready` is 1 and `out_valid` is 0.
- R10: A state offered while `in_ready` is low is not taken, and no output results from it.
- R11: Each accepted state produces exactly one single-cycle `out_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input state offered |
| in_ready | output | 1 | A slot can take a state this cycle |
| in_state | input | 768 | 12 lanes × 64 bits, lane l in bits [64l+63:64l] |
| in_tag | input | 8 | Caller tag carried with the state |
| out_valid | output | 1 | Permuted state present (one cycle) |
| out_state | output | 768 | Permuted state, same lane layout |
| out_tag | output | 8 | Tag of the returned state |

## Verification
The bench compares every result against a behavioural model that uses plain modular arithmetic. Inputs with all lanes at p − 1 catch a reduction that drops a carry or leaves a value between p and 2^64. A zero state and a single-lane state separate faults in the constant table from faults in the external or internal matrix, because a swapped full/partial boundary or a wrong diagonal changes every lane of the result. A held stream of eight states is used to check slot reuse. A design that refused reuse in the final round would accept the fifth state one cycle late. A design that skipped the ready check would lose or duplicate tags. A state held while all slots are busy must never reach the output.

// File: rtl/alg_perm_pkg.sv
package alg_perm_pkg;

    localparam int FW = 64;
    typedef logic [FW-1:0] felem_t;
    localparam felem_t FP = 64'hFFFF_FFFF_0000_0001;

    typedef enum logic [1:0] {SL_IDLE, SL_HEAD, SL_PART, SL_TAIL} slot_state_e;

    // 4x4 block matrix of the external layer, row-major
    localparam logic [3:0] M4TAB [16] = '{
        4'd5, 4'd7, 4'd1, 4'd3,
        4'd4, 4'd6, 4'd1, 4'd1,
        4'd1, 4'd3, 4'd5, 4'd7,
        4'd1, 4'd1, 4'd4, 4'd6
    };

    function automatic felem_t f_add(felem_t a, felem_t b);
        logic [FW:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= {1'b0, FP}) s = s - {1'b0, FP};
        return s[FW-1:0];
    endfunction

    // full product reduced with 2^64 = 2^32-1 and 2^96 = -1 (mod p)
    function automatic felem_t f_mul(felem_t a, felem_t b);
        logic [127:0] pr;
        logic [65:0]  mid;
        logic [65:0]  s;
        pr  = {64'b0, a} * {64'b0, b};
        mid = {2'b0, pr[95:64], 32'b0} - {34'b0, pr[95:64]};
        s   = {2'b0, pr[63:0]} + mid + {2'b0, FP - {32'b0, pr[127:96]}};
        for (int k = 0; k < 3; k++) begin
            if (s >= {2'b0, FP}) s = s - {2'b0, FP};
        end
        return s[63:0];
    endfunction

    // multiply by a small constant (below 16)
    function automatic felem_t f_mul_small(felem_t x, logic [3:0] k);
        logic [67:0] pr;
        logic [64:0] fold;
        logic [64:0] v;
        pr   = {4'b0, x} * {64'b0, k};
        fold = {29'b0, pr[67:64], 32'b0} - {61'b0, pr[67:64]};
        v    = {1'b0, pr[63:0]} + fold;
        if (v >= {1'b0, FP}) v = v - {1'b0, FP};
        return v[63:0];
    endfunction

    function automatic felem_t f_pow7(felem_t x);
        felem_t x2, x3, x6;
        x2 = f_mul(x, x);
        x3 = f_mul(x2, x);
        x6 = f_mul(x3, x3);
        return f_mul(x6, x);
    endfunction

    function automatic felem_t f_rc(int r, int l, int lanes);
        logic [63:0] v;
        v = 64'(r * lanes + l + 1) * 64'h9E37_79B9_7F4A_7C15;
        v = v ^ (v >> 29);
        if (v >= FP) v = v - FP;
        return v;
    endfunction

endpackage

// File: rtl/alg_perm_extmix.sv
module alg_perm_extmix
    import alg_perm_pkg::*;
#(
    parameter int LANES = 12,
    localparam int BLKS = LANES / 4
) (
    input  felem_t x_i [LANES],
    output felem_t y_o [LANES]
);

    felem_t blk  [LANES];
    felem_t csum [4];

    always_comb begin
        felem_t acc;
        for (int b = 0; b < BLKS; b++) begin
            for (int j = 0; j < 4; j++) begin
                acc = '0;
                for (int k = 0; k < 4; k++) begin
                    acc = f_add(acc, f_mul_small(x_i[b*4+k], M4TAB[j*4+k]));
                end
                blk[b*4+j] = acc;
            end
        end
        for (int j = 0; j < 4; j++) begin
            acc = '0;
            for (int b = 0; b < BLKS; b++) acc = f_add(acc, blk[b*4+j]);
            csum[j] = acc;
        end
        for (int i = 0; i < LANES; i++) y_o[i] = f_add(blk[i], csum[i%4]);
    end

endmodule

// File: rtl/alg_perm_round.sv
module alg_perm_round
    import alg_perm_pkg::*;
#(
    parameter int LANES     = 12,
    parameter int FULL_HEAD = 4,
    parameter int PARTIAL   = 14,
    parameter int FULL_TAIL = 4,
    localparam int ROUNDS   = FULL_HEAD + PARTIAL + FULL_TAIL,
    localparam int RW       = $clog2(ROUNDS)
) (
    input  felem_t          st_i [LANES],
    input  logic [RW-1:0]   rnd_i,
    input  logic            full_i,
    output felem_t          st_o [LANES]
);

    felem_t rc_tab [ROUNDS][LANES];
    felem_t sbo    [LANES];
    felem_t ext_y  [LANES];
    felem_t int_y  [LANES];

    for (genvar r = 0; r < ROUNDS; r++) begin : g_rc_r
        for (genvar l = 0; l < LANES; l++) begin : g_rc_l
            assign rc_tab[r][l] = f_rc(r, l, LANES);
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        if (l == 0) begin : g_lead
            // lane 0 takes constant and S-box in every round
            assign sbo[l] = f_pow7(f_add(st_i[l], rc_tab[rnd_i][l]));
        end else begin : g_rest
            felem_t pw;
            assign pw     = f_pow7(f_add(st_i[l], rc_tab[rnd_i][l]));
            assign sbo[l] = full_i ? pw : st_i[l];
        end
    end

    alg_perm_extmix #(.LANES(LANES)) u_ext (
        .x_i (sbo),
        .y_o (ext_y)
    );

    always_comb begin
        felem_t tot;
        tot = '0;
        for (int i = 0; i < LANES; i++) tot = f_add(tot, sbo[i]);
        for (int i = 0; i < LANES; i++) int_y[i] = f_add(tot, f_mul_small(sbo[i], 4'(i + 1)));
    end

    always_comb begin
        for (int i = 0; i < LANES; i++) st_o[i] = full_i ? ext_y[i] : int_y[i];
    end

endmodule

// File: rtl/alg_perm_slot.sv
module alg_perm_slot
    import alg_perm_pkg::*;
#(
    parameter int LANES     = 12,
    parameter int FULL_HEAD = 4,
    parameter int PARTIAL   = 14,
    parameter int FULL_TAIL = 4,
    parameter int TAG_W     = 8,
    localparam int ROUNDS   = FULL_HEAD + PARTIAL + FULL_TAIL,
    localparam int RW       = $clog2(ROUNDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  felem_t           load_st_i [LANES],
    input  logic [TAG_W-1:0] load_tag_i,
    output logic             free_o,
    output logic             done_o,
    output felem_t           res_st_o [LANES],
    output logic [TAG_W-1:0] res_tag_o
);

    localparam logic [RW-1:0] HEAD_END = RW'(FULL_HEAD - 1);
    localparam logic [RW-1:0] PART_BEG = RW'(FULL_HEAD);
    localparam logic [RW-1:0] PART_END = RW'(FULL_HEAD + PARTIAL - 1);
    localparam logic [RW-1:0] LAST_RND = RW'(ROUNDS - 1);

    slot_state_e      st_q, st_d;
    logic [RW-1:0]    rnd_q;
    felem_t           data_q  [LANES];
    felem_t           rnd_out [LANES];
    felem_t           res_q   [LANES];
    logic [TAG_W-1:0] tag_q, res_tag_q;
    logic             done_q;
    logic             busy, full, last;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SL_IDLE;
        else        st_q <= st_d;
    end

    // next state and decoded outputs
    always_comb begin
        st_d = st_q;
        busy = 1'b1;
        full = 1'b0;
        last = 1'b0;
        unique case (st_q)
            SL_IDLE: begin
                busy = 1'b0;
                if (load_i) st_d = SL_HEAD;
            end
            SL_HEAD: begin
                full = 1'b1;
                if (rnd_q == HEAD_END) st_d = SL_PART;
            end
            SL_PART: begin
                if (rnd_q == PART_END) st_d = SL_TAIL;
            end
            SL_TAIL: begin
                full = 1'b1;
                if (rnd_q == LAST_RND) begin
                    last = 1'b1;
                    st_d = load_i ? SL_HEAD : SL_IDLE;
                end
            end
        endcase
    end

    assign free_o = !busy || last;

    alg_perm_round #(
        .LANES(LANES), .FULL_HEAD(FULL_HEAD), .PARTIAL(PARTIAL), .FULL_TAIL(FULL_TAIL)
    ) u_round (
        .st_i   (data_q),
        .rnd_i  (rnd_q),
        .full_i (full),
        .st_o   (rnd_out)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rnd_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= last;
            if (load_i || last) rnd_q <= '0;
            else if (busy)      rnd_q <= rnd_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (load_i) begin
            data_q <= load_st_i;
            tag_q  <= load_tag_i;
        end else if (busy) begin
            data_q <= rnd_out;
        end
        if (last) begin
            res_q     <= rnd_out;
            res_tag_q <= tag_q;
        end
    end

    assign done_o    = done_q;
    assign res_st_o  = res_q;
    assign res_tag_o = res_tag_q;

    // R7: the allocator only loads a slot that is empty or finishing
    assert_load_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> free_o);

    // R2: the partial phase covers exactly the middle rounds
    assert_part_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SL_PART) |-> (rnd_q >= PART_BEG && rnd_q <= PART_END));

    // R6: a load starts the first full round at round 0
    assert_load_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (st_q == SL_HEAD && rnd_q == '0));

    // R11: a completion is a single-cycle pulse
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

endmodule

// File: rtl/alg_perm_core.sv
module alg_perm_core
    import alg_perm_pkg::*;
#(
    parameter int LANES     = 12,
    parameter int SLOTS     = 4,
    parameter int FULL_HEAD = 4,
    parameter int PARTIAL   = 14,
    parameter int FULL_TAIL = 4,
    parameter int TAG_W     = 8,
    localparam int SW       = LANES * FW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [SW-1:0]    in_state,
    input  logic [TAG_W-1:0] in_tag,
    output logic             out_valid,
    output logic [SW-1:0]    out_state,
    output logic [TAG_W-1:0] out_tag
);

    felem_t           in_arr  [LANES];
    felem_t           pre_arr [LANES];
    felem_t           out_arr [LANES];
    felem_t           res     [SLOTS][LANES];
    logic [TAG_W-1:0] rtag    [SLOTS];
    logic [SLOTS-1:0] free, grant, load, done;

    for (genvar l = 0; l < LANES; l++) begin : g_io
        assign in_arr[l]            = in_state[l*FW +: FW];
        assign out_state[l*FW +: FW] = out_arr[l];
    end

    // external layer applied once before round 0
    alg_perm_extmix #(.LANES(LANES)) u_premix (
        .x_i (in_arr),
        .y_o (pre_arr)
    );

    // lowest-index free slot wins
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (free[s] && !found) begin
                grant[s] = 1'b1;
                found    = 1'b1;
            end
        end
    end

    assign in_ready = |free;
    assign load     = grant & {SLOTS{in_valid}};

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        alg_perm_slot #(
            .LANES(LANES), .FULL_HEAD(FULL_HEAD), .PARTIAL(PARTIAL),
            .FULL_TAIL(FULL_TAIL), .TAG_W(TAG_W)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     (load[s]),
            .load_st_i  (pre_arr),
            .load_tag_i (in_tag),
            .free_o     (free[s]),
            .done_o     (done[s]),
            .res_st_o   (res[s]),
            .res_tag_o  (rtag[s])
        );
    end

    always_comb begin
        out_tag = '0;
        for (int l = 0; l < LANES; l++) out_arr[l] = '0;
        for (int s = 0; s < SLOTS; s++) begin
            out_tag = out_tag | (rtag[s] & {TAG_W{done[s]}});
            for (int l = 0; l < LANES; l++) out_arr[l] = out_arr[l] | (res[s][l] & {FW{done[s]}});
        end
    end

    assign out_valid = |done;

    // R8: slots never complete together, so the output order is the accept order
    assert_single_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done));

    // R1: every returned lane is a canonical field element
    always @(posedge clk) begin
        if (rst_n && out_valid) begin
            for (int l = 0; l < LANES; l++) begin
                assert_canon_R1: assert (out_arr[l] < FP)
                    else $error("lane %0d not canonical", l);
            end
        end
    end

endmodule

// File: tb/alg_perm_core_tb.sv
module alg_perm_core_tb;

    localparam logic [63:0] P = 64'hFFFF_FFFF_0000_0001;
    localparam int NL = 12;
    typedef logic [63:0] st_t [NL];
    localparam logic [63:0] MT [16] = '{64'd5, 64'd7, 64'd1, 64'd3, 64'd4, 64'd6, 64'd1, 64'd1,
                                        64'd1, 64'd3, 64'd5, 64'd7, 64'd1, 64'd1, 64'd4, 64'd6};

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic         in_ready;
    logic [767:0] in_state;
    logic [7:0]   in_tag;
    logic         out_valid;
    logic [767:0] out_state;
    logic [7:0]   out_tag;

    alg_perm_core u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_state(in_state), .in_tag(in_tag), .out_valid(out_valid),
        .out_state(out_state), .out_tag(out_tag)
    );

    always #10 clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [767:0] mon_d [64];
    logic [7:0]   mon_t [64];
    int           mon_c [64];
    int           n_mon = 0;
    logic [767:0] acc_e [64];
    logic [7:0]   acc_t [64];
    int           acc_c [64];
    int           n_acc = 0;
    logic [63:0]  rng = 64'h1234_5678_9ABC_DEF1;

    always @(negedge clk) begin
        if (rst_n && out_valid && n_mon < 64) begin
            mon_d[n_mon] = out_state;
            mon_t[n_mon] = out_tag;
            mon_c[n_mon] = cyc;
            n_mon = n_mon + 1;
        end
    end

    // ---------------- behavioural model ----------------
    function automatic logic [63:0] m_mul(logic [63:0] a, logic [63:0] b);
        logic [127:0] pr;
        pr = {64'b0, a} * {64'b0, b};
        return 64'(pr % {64'b0, P});
    endfunction
    function automatic logic [63:0] m_add(logic [63:0] a, logic [63:0] b);
        logic [64:0] s;
        s = {1'b0, a} + {1'b0, b};
        return 64'(s % {1'b0, P});
    endfunction
    function automatic logic [63:0] m_pow7(logic [63:0] x);
        logic [63:0] r;
        r = 64'd1;
        for (int k = 0; k < 7; k++) r = m_mul(r, x);
        return r;
    endfunction
    function automatic logic [63:0] m_rc(int r, int l);
        logic [63:0] v;
        v = 64'(r * 12 + l + 1) * 64'h9E37_79B9_7F4A_7C15;
        v = v ^ (v >> 29);
        return v % P;
    endfunction
    function automatic st_t m_ext(st_t x);
        st_t t, y;
        for (int b = 0; b < 3; b++)
            for (int j = 0; j < 4; j++) begin
                t[b*4+j] = 64'd0;
                for (int k = 0; k < 4; k++) t[b*4+j] = m_add(t[b*4+j], m_mul(MT[j*4+k], x[b*4+k]));
            end
        for (int i = 0; i < NL; i++) begin
            y[i] = t[i];
            for (int b = 0; b < 3; b++) y[i] = m_add(y[i], t[b*4 + i%4]);
        end
        return y;
    endfunction
    function automatic logic [767:0] model(logic [767:0] d);
        st_t s, n;
        logic [63:0] sum;
        logic [767:0] o;
        for (int l = 0; l < NL; l++) s[l] = d[l*64 +: 64];
        s = m_ext(s);
        for (int r = 0; r < 22; r++) begin
            bit full;
            full = (r < 4) || (r >= 18);
            for (int l = 0; l < NL; l++)
                if (full || l == 0) s[l] = m_pow7(m_add(s[l], m_rc(r, l)));
            if (full) s = m_ext(s);
            else begin
                sum = 64'd0;
                for (int l = 0; l < NL; l++) sum = m_add(sum, s[l]);
                for (int l = 0; l < NL; l++) n[l] = m_add(sum, m_mul(64'(l + 1), s[l]));
                s = n;
            end
        end
        for (int l = 0; l < NL; l++) o[l*64 +: 64] = s[l];
        return o;
    endfunction

    function automatic logic [767:0] rand_state();
        logic [767:0] o;
        for (int l = 0; l < NL; l++) begin
            rng = rng ^ (rng << 13);
            rng = rng ^ (rng >> 7);
            rng = rng ^ (rng << 17);
            o[l*64 +: 64] = rng % P;
        end
        return o;
    endfunction

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input logic [767:0] act, input logic [767:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [767:0] d, input logic [7:0] tg);
        in_valid = 1'b1;
        in_state = d;
        in_tag   = tg;
        while (!in_ready) @(negedge clk);
        acc_c[n_acc] = cyc + 1;
        acc_t[n_acc] = tg;
        acc_e[n_acc] = model(d);
        n_acc++;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check_results(input int a0, input int m0, input int cnt, input string req);
        chk(n_mon - m0 == cnt, "R11", "output count", 768'(n_mon - m0), 768'(cnt));
        for (int k = 0; k < cnt; k++) begin
            if (m0 + k < n_mon) begin
                chk(mon_d[m0+k] == acc_e[a0+k], req, "state", mon_d[m0+k], acc_e[a0+k]);
                chk(mon_t[m0+k] == acc_t[a0+k], "R8", "tag order", 768'(mon_t[m0+k]), 768'(acc_t[a0+k]));
                chk(mon_c[m0+k] - acc_c[a0+k] == 22, "R6", "latency",
                    768'(mon_c[m0+k] - acc_c[a0+k]), 768'(22));
            end
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(in_ready == 1'b1, "R9", "ready in reset", 768'(in_ready), 768'(1));
        chk(out_valid == 1'b0, "R9", "valid in reset", 768'(out_valid), 768'(0));
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R9", "ready after reset", 768'(in_ready), 768'(1));
        chk(out_valid == 1'b0, "R9", "valid after reset", 768'(out_valid), 768'(0));
    endtask

    // zero input: result depends on the constant table alone (R5)
    task automatic t_zero();
        int a0 = n_acc, m0 = n_mon;
        send('0, 8'h05);
        repeat (30) @(negedge clk);
        check_results(a0, m0, 1, "R5");
    endtask

    // one nonzero lane exercises both matrices (R3 R4)
    task automatic t_onelane();
        int a0 = n_acc, m0 = n_mon;
        logic [767:0] d = '0;
        d[5*64 +: 64] = 64'd1;
        send(d, 8'h11);
        repeat (30) @(negedge clk);
        check_results(a0, m0, 1, "R3 R4");
    endtask

    // all lanes at p-1: reduction corner (R1)
    task automatic t_edge();
        int a0 = n_acc, m0 = n_mon;
        logic [767:0] d;
        for (int l = 0; l < NL; l++) d[l*64 +: 64] = P - 64'd1;
        send(d, 8'h22);
        repeat (30) @(negedge clk);
        check_results(a0, m0, 1, "R1");
        if (m0 < n_mon) begin
            bit canon = 1'b1;
            for (int l = 0; l < NL; l++) if (mon_d[m0][l*64 +: 64] >= P) canon = 1'b0;
            chk(canon, "R1", "canonical lanes", 768'(canon), 768'(1));
        end
    endtask

    // held stream of eight states: overlap, reuse and order (R7 R8 R2)
    task automatic t_burst();
        int a0 = n_acc, m0 = n_mon;
        for (int k = 0; k < 8; k++) send(rand_state(), 8'(8'h40 + k));
        repeat (30) @(negedge clk);
        for (int k = 1; k < 4; k++)
            chk(acc_c[a0+k] - acc_c[a0+k-1] == 1, "R7", "back-to-back accept",
                768'(acc_c[a0+k] - acc_c[a0+k-1]), 768'(1));
        chk(acc_c[a0+4] - acc_c[a0] == 22, "R7", "slot reuse cycle",
            768'(acc_c[a0+4] - acc_c[a0]), 768'(22));
        check_results(a0, m0, 8, "R2");
    endtask

    // state held while all slots busy is never taken (R10)
    task automatic t_ignore();
        int a0 = n_acc, m0 = n_mon;
        bit seen = 1'b0;
        bit blocked = 1'b1;
        for (int k = 0; k < 4; k++) send(rand_state(), 8'(8'h60 + k));
        in_valid = 1'b1;
        in_state = rand_state();
        in_tag   = 8'hEE;
        for (int k = 0; k < 10; k++) begin
            if (in_ready) blocked = 1'b0;
            @(negedge clk);
        end
        in_valid = 1'b0;
        chk(blocked, "R7", "ready low when full", 768'(!blocked), 768'(0));
        repeat (40) @(negedge clk);
        check_results(a0, m0, 4, "R2");
        for (int k = m0; k < n_mon; k++) if (mon_t[k] == 8'hEE) seen = 1'b1;
        chk(!seen, "R10", "blocked state emitted", 768'(seen), 768'(0));
    endtask

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_state = '0;
        in_tag   = '0;
        repeat (3) @(negedge clk);
        t_reset();
        t_zero();
        t_onelane();
        t_edge();
        t_burst();
        t_ignore();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R6 watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule